// File: doc/BRIEF.md
# Processor Port Tail Tag Unit

This block sits on the processor-facing port of a small switch and handles a one-byte port tag that rides at the very end of each frame. Both directions use a byte-wide streaming handshake with valid, ready, data and last. Frames from the processor toward the switch have their final byte removed. The low bits of that byte come out as a destination mask for the forwarding logic. Frames from the switch toward the processor get one extra trailing byte, which names the port the frame entered on.

A single enable input turns tagging on. When it is low, both directions are plain wires and frames pass unchanged. The enable is expected to change only while both directions are idle. The forwarding logic reads the destination mask together with the final body beat: a mask with bit i set sends the frame to front port i, and an all-zero mask means the normal address lookup applies.

Top module: `tail_tag_unit`

## Requirements
- R1: With `tag_en_i` low, the processor-to-switch path forwards every byte, and its last flag, unchanged, and `sw_tx_dest_o` reads zero.
- R2: With `tag_en_i` low, the switch-to-processor path forwards every byte, and its last flag, unchanged, and adds no byte.
- R3: With `tag_en_i` high, a processor frame of N bytes (N >= 2) leaves toward the switch as its first N-1 bytes, in order. Last is raised on byte N-1.
- R4: With `tag_en_i` high, `sw_tx_dest_o` equals bits [NUM_PORTS-1:0] of the removed final byte on the beat that carries last, and equals zero on every other beat. Tag bits [7:4] have no effect on any output.
- R5: A tag whose low nibble is zero gives an all-zero destination mask, which selects the normal address lookup.
- R6: With `tag_en_i` high, a one-byte processor frame produces no output beat. `short_err_o` is high for exactly one cycle, the cycle after that byte is accepted.
- R7: With `tag_en_i` high, each switch frame reaches the processor with its body bytes unchanged and last low. These are followed by one extra byte whose bits [3:0] hold the ingress port number and whose bits [7:4] are zero, with last high.
- R8: Holding an output's ready low stalls that path without losing or duplicating bytes. A stalled output keeps its data and last flag stable.
- R9: The ingress port number placed in the tag is the value of `sw_rx_src_i` on the accepted last beat of the switch frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tag_en_i | input | 1 | Enables tag removal and insertion |
| cpu_rx_valid_i | input | 1 | Processor frame byte valid |
| cpu_rx_ready_o | output | 1 | Processor frame byte accepted |
| cpu_rx_data_i | input | 8 | Processor frame byte |
| cpu_rx_last_i | input | 1 | Final byte of processor frame |
| sw_tx_valid_o | output | 1 | Byte toward switch valid |
| sw_tx_ready_i | input | 1 | Switch accepts byte |
| sw_tx_data_o | output | 8 | Byte toward switch |
| sw_tx_last_o | output | 1 | Final byte toward switch |
| sw_tx_dest_o | output | NUM_PORTS | Destination mask, valid with last |
| short_err_o | output | 1 | One-cycle pulse for a dropped one-byte frame |
| sw_rx_valid_i | input | 1 | Switch frame byte valid |
| sw_rx_ready_o | output | 1 | Switch frame byte accepted |
| sw_rx_data_i | input | 8 | Switch frame byte |
| sw_rx_last_i | input | 1 | Final byte of switch frame |
| sw_rx_src_i | input | $clog2(NUM_PORTS) | Ingress port number, sampled on last |
| cpu_tx_valid_o | output | 1 | Byte toward processor valid |
| cpu_tx_ready_i | input | 1 | Processor accepts byte |
| cpu_tx_data_o | output | 8 | Byte toward processor |
| cpu_tx_last_o | output | 1 | Final byte toward processor |

## Verification
The assertions check several rules on every cycle:
- the destination mask is zero on non-final beats;
- a stalled output keeps its data stable;
- accepting a switch frame's final byte is followed at once by a tag beat with last high and a clear upper nibble;
- a one-byte processor frame raises the error pulse on the next cycle.

Only the bench's scenarios can show that whole frames arrive complete and in order, with exactly one byte removed or added. They also show that the mask is taken from the removed byte and ignores its upper nibble, and that the port number is the one sampled on the final beat. Random backpressure on both outputs at once shows that no byte is lost or duplicated.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int BYTE_W  = 8;
  localparam int NIB_W   = 4;

  typedef enum logic {
    INS_BODY = 1'b0,
    INS_TAG  = 1'b1
  } ins_state_e;
endpackage

// File: rtl/tt_strip.sv
module tt_strip
  import tt_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tag_en_i,
  input  logic                 s_valid_i,
  output logic                 s_ready_o,
  input  logic [BYTE_W-1:0]    s_data_i,
  input  logic                 s_last_i,
  output logic                 m_valid_o,
  input  logic                 m_ready_i,
  output logic [BYTE_W-1:0]    m_data_o,
  output logic                 m_last_o,
  output logic [NUM_PORTS-1:0] m_dest_o,
  output logic                 short_err_o
);
  // one-byte hold stage: a byte goes out only once its successor shows whether it was the tag
  logic              hold_vld_q;
  logic [BYTE_W-1:0] hold_q;
  logic              err_q;
  logic              in_fire;

  always_comb begin
    if (!tag_en_i) begin
      m_valid_o = s_valid_i;
      m_data_o  = s_data_i;
      m_last_o  = s_last_i;
      m_dest_o  = '0;
      s_ready_o = m_ready_i;
    end else begin
      m_valid_o = hold_vld_q && s_valid_i;
      m_data_o  = hold_q;
      m_last_o  = s_last_i;
      m_dest_o  = s_last_i ? s_data_i[NUM_PORTS-1:0] : '0;
      s_ready_o = hold_vld_q ? m_ready_i : 1'b1;
    end
  end

  assign in_fire     = s_valid_i && s_ready_o;
  assign short_err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (!tag_en_i) begin
        hold_vld_q <= 1'b0;
      end else if (in_fire) begin
        if (!hold_vld_q) begin
          if (s_last_i) begin
            err_q <= 1'b1;
          end else begin
            hold_vld_q <= 1'b1;
            hold_q     <= s_data_i;
          end
        end else if (s_last_i) begin
          hold_vld_q <= 1'b0;
        end else begin
          hold_q <= s_data_i;
        end
      end
    end
  end

  p_dest_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_last_o) |-> (m_dest_o == '0));

  p_short_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_en_i && s_valid_i && s_ready_o && s_last_i && !m_valid_o) |=> short_err_o);

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_en_i && m_valid_o && !m_ready_i) |=> $stable(m_data_o));
endmodule

// File: rtl/tt_insert.sv
module tt_insert
  import tt_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int SRC_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tag_en_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_last_i,
  input  logic [SRC_W-1:0]  s_src_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [BYTE_W-1:0] m_data_o,
  output logic              m_last_o
);
  ins_state_e       state_q;
  logic [SRC_W-1:0] src_q;

  always_comb begin
    if (state_q == INS_TAG) begin
      m_valid_o = 1'b1;
      m_data_o  = {{(BYTE_W-SRC_W){1'b0}}, src_q};
      m_last_o  = 1'b1;
      s_ready_o = 1'b0;
    end else begin
      m_valid_o = s_valid_i;
      m_data_o  = s_data_i;
      m_last_o  = s_last_i && !tag_en_i;
      s_ready_o = m_ready_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= INS_BODY;
      src_q   <= '0;
    end else begin
      case (state_q)
        INS_BODY: if (tag_en_i && s_valid_i && s_ready_o && s_last_i) begin
          state_q <= INS_TAG;
          src_q   <= s_src_i;
        end
        INS_TAG: if (m_ready_i) state_q <= INS_BODY;
        default: state_q <= INS_BODY;
      endcase
    end
  end

  p_tag_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_en_i && s_valid_i && s_ready_o && s_last_i)
      |=> (m_valid_o && m_last_o && m_data_o[7:4] == 4'h0 && !s_ready_o));

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_last_o)));
endmodule

// File: rtl/tail_tag_unit.sv
module tail_tag_unit
  import tt_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int SRC_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tag_en_i,
  input  logic                 cpu_rx_valid_i,
  output logic                 cpu_rx_ready_o,
  input  logic [7:0]           cpu_rx_data_i,
  input  logic                 cpu_rx_last_i,
  output logic                 sw_tx_valid_o,
  input  logic                 sw_tx_ready_i,
  output logic [7:0]           sw_tx_data_o,
  output logic                 sw_tx_last_o,
  output logic [NUM_PORTS-1:0] sw_tx_dest_o,
  output logic                 short_err_o,
  input  logic                 sw_rx_valid_i,
  output logic                 sw_rx_ready_o,
  input  logic [7:0]           sw_rx_data_i,
  input  logic                 sw_rx_last_i,
  input  logic [SRC_W-1:0]     sw_rx_src_i,
  output logic                 cpu_tx_valid_o,
  input  logic                 cpu_tx_ready_i,
  output logic [7:0]           cpu_tx_data_o,
  output logic                 cpu_tx_last_o
);
  tt_strip #(.NUM_PORTS(NUM_PORTS)) u_strip (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tag_en_i   (tag_en_i),
    .s_valid_i  (cpu_rx_valid_i),
    .s_ready_o  (cpu_rx_ready_o),
    .s_data_i   (cpu_rx_data_i),
    .s_last_i   (cpu_rx_last_i),
    .m_valid_o  (sw_tx_valid_o),
    .m_ready_i  (sw_tx_ready_i),
    .m_data_o   (sw_tx_data_o),
    .m_last_o   (sw_tx_last_o),
    .m_dest_o   (sw_tx_dest_o),
    .short_err_o(short_err_o)
  );

  tt_insert #(.NUM_PORTS(NUM_PORTS)) u_insert (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tag_en_i (tag_en_i),
    .s_valid_i(sw_rx_valid_i),
    .s_ready_o(sw_rx_ready_o),
    .s_data_i (sw_rx_data_i),
    .s_last_i (sw_rx_last_i),
    .s_src_i  (sw_rx_src_i),
    .m_valid_o(cpu_tx_valid_o),
    .m_ready_i(cpu_tx_ready_i),
    .m_data_o (cpu_tx_data_o),
    .m_last_o (cpu_tx_last_o)
  );
endmodule

// File: tb/sim_tail_tag_unit.sv
module sim_tail_tag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int NP         = 4;
  localparam int SW         = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tag_en = 1'b0;
  logic cpu_rx_valid = 1'b0, cpu_rx_last = 1'b0;
  logic [7:0] cpu_rx_data = '0;
  logic cpu_rx_ready;
  logic sw_tx_valid, sw_tx_last, short_err;
  logic [7:0] sw_tx_data;
  logic [NP-1:0] sw_tx_dest;
  logic sw_tx_ready = 1'b1;
  logic sw_rx_valid = 1'b0, sw_rx_last = 1'b0;
  logic [7:0] sw_rx_data = '0;
  logic [SW-1:0] sw_rx_src = '0;
  logic sw_rx_ready;
  logic cpu_tx_valid, cpu_tx_last;
  logic [7:0] cpu_tx_data;
  logic cpu_tx_ready = 1'b1;

  int checks = 0, fails = 0;
  int exp_err = 0, seen_err = 0;
  bit stall = 1'b0;
  string tag_str = "R1";
  logic [12:0] strip_q[$];  // {dest, last, data}
  logic [8:0]  ins_q[$];    // {last, data}

  always #(HALF) clk = ~clk;

  tail_tag_unit #(.NUM_PORTS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tag_en_i(tag_en),
    .cpu_rx_valid_i(cpu_rx_valid), .cpu_rx_ready_o(cpu_rx_ready),
    .cpu_rx_data_i(cpu_rx_data), .cpu_rx_last_i(cpu_rx_last),
    .sw_tx_valid_o(sw_tx_valid), .sw_tx_ready_i(sw_tx_ready),
    .sw_tx_data_o(sw_tx_data), .sw_tx_last_o(sw_tx_last),
    .sw_tx_dest_o(sw_tx_dest), .short_err_o(short_err),
    .sw_rx_valid_i(sw_rx_valid), .sw_rx_ready_o(sw_rx_ready),
    .sw_rx_data_i(sw_rx_data), .sw_rx_last_i(sw_rx_last), .sw_rx_src_i(sw_rx_src),
    .cpu_tx_valid_o(cpu_tx_valid), .cpu_tx_ready_i(cpu_tx_ready),
    .cpu_tx_data_o(cpu_tx_data), .cpu_tx_last_o(cpu_tx_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    sw_tx_ready  <= stall ? ($urandom % 3 != 0) : 1'b1;
    cpu_tx_ready <= stall ? ($urandom % 3 != 0) : 1'b1;
  end

  // monitors sample just before the rising edge
  logic       prev_stall = 1'b0;
  logic [8:0] prev_beat  = '0;
  always begin
    @(negedge clk);
    #(HALF - 1);
    if (rst_n) begin
      if (short_err) seen_err++;
      if (sw_tx_valid && sw_tx_ready) begin
        if (strip_q.size() == 0) check({tag_str, " strip extra beat"}, 1, 0);
        else check({tag_str, " strip beat"}, {19'd0, sw_tx_dest, sw_tx_last, sw_tx_data},
                   {19'd0, strip_q.pop_front()});
      end
      if (prev_stall) check("R8 stalled beat held", {23'd0, cpu_tx_valid, cpu_tx_last, cpu_tx_data},
                            {23'd0, 1'b1, prev_beat});
      prev_stall = cpu_tx_valid && !cpu_tx_ready;
      prev_beat  = {cpu_tx_last, cpu_tx_data};
      if (cpu_tx_valid && cpu_tx_ready) begin
        if (ins_q.size() == 0) check({tag_str, " insert extra beat"}, 1, 0);
        else check({tag_str, " insert beat"}, {23'd0, cpu_tx_last, cpu_tx_data},
                   {23'd0, ins_q.pop_front()});
      end
    end
  end

  // drive at the falling edge, handshake judged just before the next rising edge
  task automatic send_strip(input int len, input logic [7:0] seed, input logic [7:0] tag);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = (i == len - 1) ? tag : seed + 8'(i);
      if (tag_en) begin
        if (len < 2) begin
          if (i == 0) exp_err++;
        end else if (i < len - 1)
          strip_q.push_back({(i == len - 2) ? tag[NP-1:0] : 4'h0, i == len - 2, b});
      end else strip_q.push_back({4'h0, i == len - 1, b});
    end
    for (int i = 0; i < len; i++) begin
      bit fire;
      cpu_rx_valid = 1'b1;
      cpu_rx_data  = (i == len - 1) ? tag : seed + 8'(i);
      cpu_rx_last  = (i == len - 1);
      do begin
        #(HALF - 1);
        fire = cpu_rx_ready;
        @(negedge clk);
      end while (!fire);
    end
    cpu_rx_valid = 1'b0;
    cpu_rx_last  = 1'b0;
  endtask

  task automatic send_insert(input int len, input logic [7:0] seed, input logic [SW-1:0] src);
    for (int i = 0; i < len; i++) begin
      if (tag_en) ins_q.push_back({1'b0, seed + 8'(i)});
      else ins_q.push_back({i == len - 1, seed + 8'(i)});
    end
    if (tag_en) ins_q.push_back({1'b1, 4'h0, 2'b00, src});
    for (int i = 0; i < len; i++) begin
      bit fire;
      sw_rx_valid = 1'b1;
      sw_rx_data  = seed + 8'(i);
      sw_rx_last  = (i == len - 1);
      sw_rx_src   = (i == len - 1) ? src : ~src;  // R9: only the last beat counts
      do begin
        #(HALF - 1);
        fire = sw_rx_ready;
        @(negedge clk);
      end while (!fire);
    end
    sw_rx_valid = 1'b0;
    sw_rx_last  = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((strip_q.size() != 0 || ins_q.size() != 0) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  bit done = 1'b0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R3 and R7: nothing offered
    check("R3 reset sw_tx_valid", sw_tx_valid, 0);
    check("R7 reset cpu_tx_valid", cpu_tx_valid, 0);
    check("R6 reset short_err", short_err, 0);

    tag_str = "R1";
    send_strip(1, 8'h10, 8'hA1);
    send_strip(3, 8'h20, 8'hB2);
    send_strip(5, 8'h30, 8'hC3);
    tag_str = "R2";
    send_insert(1, 8'h40, 2'd1);
    send_insert(4, 8'h50, 2'd3);
    drain();

    tag_en = 1'b1;
    @(negedge clk);
    tag_str = "R3/R4";
    send_strip(2, 8'h60, 8'hF5);   // R4 upper nibble ignored, mask 0101
    send_strip(4, 8'h70, 8'h3C);
    tag_str = "R5";
    send_strip(6, 8'h80, 8'hE0);   // R5 zero nibble -> lookup
    tag_str = "R6";
    send_strip(1, 8'h90, 8'h42);
    send_strip(1, 8'h91, 8'h43);
    tag_str = "R3";
    send_strip(3, 8'hA0, 8'h08);
    tag_str = "R7/R9";
    send_insert(1, 8'hB0, 2'd2);
    send_insert(4, 8'hC0, 2'd3);
    send_insert(3, 8'hD0, 2'd0);
    drain();
    check("R6 short frames flagged", seen_err, exp_err);

    stall = 1'b1;
    tag_str = "R8";
    fork
      for (int k = 0; k < 12; k++) send_strip(1 + (k % 5), 8'(k * 16), 8'(k * 7 + 1));
      for (int k = 0; k < 12; k++) send_insert(1 + (k % 4), 8'(k * 9), 2'(k));
    join
    drain();
    stall = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 short frames flagged under stall", seen_err, exp_err);
    check("R8 strip queue empty", strip_q.size(), 0);
    check("R8 insert queue empty", ins_q.size(), 0);

    tag_en = 1'b0;
    @(negedge clk);
    tag_str = "R1";
    send_strip(2, 8'hE0, 8'h55);
    tag_str = "R2";
    send_insert(2, 8'hF0, 2'd1);
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule